// File: doc/BRIEF.md
# Pipeline Stage Register with Stall, Bubble and Conflict Detection

This block is one stage register in a processor pipeline. It stores a payload word of configurable width and a small status code that travels with it. On every clock edge, two request lines from the hazard logic pick what happens:

- **Load:** with neither request raised, the register takes the values offered by the preceding stage.
- **Hold:** a stall request keeps the stored contents.
- **Bubble:** a bubble request replaces the contents with a fixed bubble payload and a bubble status.

The hazard logic should never raise both requests in the same cycle. If it does, the register does not quietly pick one of them. It treats the pair as a control fault. The payload is held and the stored status becomes a dedicated pipeline-error code, so the fault travels down the pipe with the instruction. A conflict flag is raised in the cycle after the faulty edge. A two-bit code shows which operation the current requests select.

The bubble payload, the bubble status and the error status are all parameters. Synchronous reset fills the stage with a bubble.

Top module: `pipe_stage_reg`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at an edge, the register loads `BUBBLE_DATA` and `BUBBLE_STAT` and clears `conflict`, whatever the request inputs are.
- R2: An edge with `hold_req`=1 and `flush_req`=0 leaves `cur_data` and `cur_stat` unchanged.
- R3: An edge with `flush_req`=1 and `hold_req`=0 loads `BUBBLE_DATA` into `cur_data` and `BUBBLE_STAT` into `cur_stat`.
- R4: An edge with both requests at 0 loads `nxt_data` into `cur_data` and `nxt_stat` into `cur_stat`.
- R5: An edge with both requests at 1 keeps `cur_data` unchanged and sets `cur_stat` to `FAULT_STAT`.
- R6: `conflict` is 1 for the cycle after each edge at which both requests were 1, and 0 after any other edge.
- R7: `op_code` follows the present requests without a clock: 0 for load, 1 for hold, 2 for bubble, 3 for the conflict case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Stall request: keep the contents |
| flush_req | input | 1 | Bubble request: insert a bubble |
| nxt_data | input | DATA_W | Payload offered by the preceding stage |
| nxt_stat | input | STAT_W | Status offered by the preceding stage |
| cur_data | output | DATA_W | Stored payload |
| cur_stat | output | STAT_W | Stored status |
| op_code | output | 2 | Selected operation (0 load, 1 hold, 2 bubble, 3 conflict) |
| conflict | output | 1 | Registered flag: the previous edge had both requests raised |

## Verification
The bench builds the stage with a 4-bit payload, a 3-bit status, a bubble payload of 5, a bubble status of 4 and an error status of 6. These sizes are small enough to drive every request pair with every payload and status value, 512 edges in all. Because of that, each operation is seen starting from many different stored values, and runs of consecutive conflicts appear naturally. Reset is also applied in the middle of the run, with both requests raised, to confirm that reset takes precedence over the requests.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

  // Encoding of the operation selected by the request pair {flush, hold}
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_HOLD   = 2'd1,
    OP_BUBBLE = 2'd2,
    OP_FAULT  = 2'd3
  } stage_op_e;

endpackage

// File: rtl/stage_ctl.sv
module stage_ctl
  import pipe_stage_pkg::*;
(
  input  logic      hold_req,
  input  logic      flush_req,
  output stage_op_e op
);

  always_comb begin
    unique case ({flush_req, hold_req})
      2'b00:   op = OP_LOAD;
      2'b01:   op = OP_HOLD;
      2'b10:   op = OP_BUBBLE;
      default: op = OP_FAULT;
    endcase
  end

endmodule

// File: rtl/stage_field.sv
module stage_field
  import pipe_stage_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] BUBBLE_VAL = '0,
  parameter bit           OVERWRITE  = 1'b0,
  parameter logic [W-1:0] FAULT_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  stage_op_e    op,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);

  logic [W-1:0] fault_next;

  // Variant choice: a conflict either writes a code or keeps the field
  generate
    if (OVERWRITE) begin : g_force
      assign fault_next = FAULT_VAL;
    end else begin : g_keep
      assign fault_next = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= BUBBLE_VAL;
    end else begin
      case (op)
        OP_LOAD:   q <= nxt;
        OP_HOLD:   q <= q;
        OP_BUBBLE: q <= BUBBLE_VAL;
        default:   q <= fault_next;
      endcase
    end
  end

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
  import pipe_stage_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                STAT_W      = 3,
  parameter logic [DATA_W-1:0] BUBBLE_DATA = '0,
  parameter logic [STAT_W-1:0] BUBBLE_STAT = 3'd4,
  parameter logic [STAT_W-1:0] FAULT_STAT  = 3'd6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_req,
  input  logic              flush_req,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [STAT_W-1:0] nxt_stat,
  output logic [DATA_W-1:0] cur_data,
  output logic [STAT_W-1:0] cur_stat,
  output logic [1:0]        op_code,
  output logic              conflict
);

  stage_op_e op;

  stage_ctl u_ctl (
    .hold_req  (hold_req),
    .flush_req (flush_req),
    .op        (op)
  );

  assign op_code = op;

  // Payload keeps its value on a conflict
  stage_field #(
    .W          (DATA_W),
    .BUBBLE_VAL (BUBBLE_DATA),
    .OVERWRITE  (1'b0),
    .FAULT_VAL  ('0)
  ) u_data (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .nxt (nxt_data),
    .q   (cur_data)
  );

  // Status is overwritten with the error code on a conflict
  stage_field #(
    .W          (STAT_W),
    .BUBBLE_VAL (BUBBLE_STAT),
    .OVERWRITE  (1'b1),
    .FAULT_VAL  (FAULT_STAT)
  ) u_stat (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .nxt (nxt_stat),
    .q   (cur_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) conflict <= 1'b0;
    else     conflict <= (op == OP_FAULT);
  end

  // R2
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    (hold_req && !flush_req) |=> ($stable(cur_data) && $stable(cur_stat)));

  // R3
  a_r3_bubble_loads: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !hold_req) |=> (cur_data == BUBBLE_DATA && cur_stat == BUBBLE_STAT));

  // R4
  a_r4_load_takes_next: assert property (@(posedge clk) disable iff (rst)
    (!flush_req && !hold_req) |=> (cur_data == $past(nxt_data) && cur_stat == $past(nxt_stat)));

  // R5
  a_r5_fault_status: assert property (@(posedge clk) disable iff (rst)
    (flush_req && hold_req) |=> ($stable(cur_data) && cur_stat == FAULT_STAT));

  // R6
  a_r6_flag_on_fault: assert property (@(posedge clk) disable iff (rst)
    (flush_req && hold_req) |=> conflict);

  // R6
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    !(flush_req && hold_req) |=> !conflict);

  // R7
  always_comb begin
    a_r7_code_map: assert (op_code == {flush_req, hold_req});
  end

endmodule

// File: tb/tb_pipe_stage_reg.sv
`timescale 1ns/1ps
module tb_pipe_stage_reg;

  localparam int          DW = 4;
  localparam int          SW = 3;
  localparam logic [3:0]  BD = 4'h5;
  localparam logic [2:0]  BS = 3'd4;
  localparam logic [2:0]  FS = 3'd6;

  logic          clk = 1'b0;
  logic          rst;
  logic          hold_req, flush_req;
  logic [DW-1:0] nxt_data;
  logic [SW-1:0] nxt_stat;
  logic [DW-1:0] cur_data;
  logic [SW-1:0] cur_stat;
  logic [1:0]    op_code;
  logic          conflict;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] m_data;
  logic [SW-1:0] m_stat;
  logic          m_flag;

  always #10 clk = ~clk;

  pipe_stage_reg #(
    .DATA_W (DW), .STAT_W (SW),
    .BUBBLE_DATA (BD), .BUBBLE_STAT (BS), .FAULT_STAT (FS)
  ) dut (
    .clk (clk), .rst (rst),
    .hold_req (hold_req), .flush_req (flush_req),
    .nxt_data (nxt_data), .nxt_stat (nxt_stat),
    .cur_data (cur_data), .cur_stat (cur_stat),
    .op_code (op_code), .conflict (conflict)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " data"}, int'(cur_data), int'(m_data));
    check({req, " stat"}, int'(cur_stat), int'(m_stat));
    check({req, " flag"}, int'(conflict), int'(m_flag));
  endtask

  // One edge with the given requests, model updated from the requirements
  task automatic step(input logic h, input logic f, input logic [DW-1:0] d, input logic [SW-1:0] s);
    @(negedge clk);
    hold_req = h; flush_req = f; nxt_data = d; nxt_stat = s;
    #1;
    check("R7 op_code", int'(op_code), int'({f, h}));
    @(posedge clk);
    #1;
    if (!h && !f) begin m_data = d; m_stat = s; m_flag = 1'b0; end      // R4
    else if (h && !f) begin m_flag = 1'b0; end                          // R2
    else if (!h && f) begin m_data = BD; m_stat = BS; m_flag = 1'b0; end // R3
    else begin m_stat = FS; m_flag = 1'b1; end                           // R5, R6
    if (!h && !f)     check_state("R4 load");
    else if (h && !f) check_state("R2 hold");
    else if (!h && f) check_state("R3 bubble");
    else              check_state("R5_R6 conflict");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hold_req = 1'b1; flush_req = 1'b1; nxt_data = 4'hF; nxt_stat = 3'd7;
    @(posedge clk);
    #1;
    m_data = BD; m_stat = BS; m_flag = 1'b0;
    check_state("R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; hold_req = 1'b0; flush_req = 1'b0; nxt_data = '0; nxt_stat = '0;
    m_data = BD; m_stat = BS; m_flag = 1'b0;
    do_reset();
    // Full sweep: every request pair with every payload and status value
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 16; d++) begin
        for (int s = 0; s < 8; s++) begin
          step(r[0], r[1], DW'(d), SW'(s));
        end
      end
    end
    // Interleaved pattern: load, conflict, hold, conflict, bubble, load
    for (int d = 0; d < 16; d++) begin
      step(1'b0, 1'b0, DW'(d), SW'(d));
      step(1'b1, 1'b1, DW'(d ^ 15), SW'(d + 1));
      step(1'b1, 1'b0, DW'(d + 3), SW'(d + 2));
      step(1'b1, 1'b1, DW'(d + 7), SW'(d + 5));
      step(1'b0, 1'b1, DW'(d + 9), SW'(d + 6));
      step(1'b0, 1'b0, DW'(d * 3), SW'(d * 5));
    end
    // R1: reset in mid-run overrides a pending conflict
    step(1'b1, 1'b1, 4'h3, 3'd1);
    do_reset();
    step(1'b0, 1'b0, 4'hC, 3'd2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule